// File: doc/BRIEF.md
# Machine Control Register with Coprocessor Trap Decision

This block holds the machine-control word of a protected-mode core: the protection and paging enables, the supervisor write-protect bit, the numeric-error reporting bit and the four bits that govern the floating-point coprocessor. Software writes the word through a single write port. Each write is checked before it is accepted. A write that would turn paging on while protection stays off is refused: the word keeps its old value and a one-cycle general-protection pulse is raised. The hardware sets the task-switched bit whenever the core reports a task switch.

The instruction decoder presents a strobe for each floating-point instruction and each wait instruction. In the same cycle, the block answers combinationally whether a device-not-available fault must be taken. The answer depends on the emulate, monitor and task-switched bits. A strap gives the coprocessor protocol type, which is captured during reset.

Beside the control word sit a parameterised number of descriptor-table registers. Each holds a base and a limit, is loaded whole on a strobe, and is presented continuously for store instructions. The protection and paging enables are held in a mode state machine with three states. MODE_REAL has both enables clear. MODE_PROT has protection only. MODE_PAGED has protection and paging. Any accepted write moves the machine directly to the state its data encodes, so every transition between the three states is possible, including MODE_REAL to MODE_PAGED in a single write, and every state may also stay put. A refused write keeps the current state.

Top module: `mcr_top`

## Requirements
- R1: While `rst_n` is low on a clock edge, the control word is cleared except bit 4, which captures `cop_type_strap`. After reset, `cr_rd_data` is 32'h10 with the strap at 1, and 32'h0 with the strap at 0.
- R2: The control word has this field layout. Protection-enable is bit 0, monitor is bit 1, emulate is bit 2, task-switched is bit 3, extension-type is bit 4, numeric-error is bit 5, write-protect is bit 16 and paging is bit 31. All other bits read 0. An accepted write loads bits 0-3, 5, 16 and 31 from `cr_wr_data` and never changes bit 4. A write of 32'hFFFFFFFF with bit 4 set reads back as 32'h8001003F.
- R3: A write with bit 31 set and bit 0 clear is refused. The word is unchanged, apart from the task-switched rule in R5. `gp_fault` is high for exactly the one cycle that follows the write edge. `gp_fault` is never high otherwise. Bit 31 never reads 1 while bit 0 reads 0.
- R4: A write that sets bits 31 and 0 together is accepted, whatever the previous mode was.
- R5: A `task_sw` strobe sets bit 3 at the next edge. If a write arrives in the same cycle, the write decides every other bit, and bit 3 still ends up set.
- R6: While `fp_insn` is high and emulate (bit 2) is 1, `dna_fault` is high in the same cycle.
- R7: While `fp_insn` is high and emulate is 0, `dna_fault` equals task-switched (bit 3).
- R8: While `wait_insn` is high alone, `dna_fault` is high only if monitor (bit 1) and task-switched are both 1. With monitor at 0, task-switched has no effect, and emulate never affects a wait.
- R9: `ext_proto32` is bit 4 AND NOT bit 2, so the captured type is ignored while emulate is 1.
- R10: After reset, every descriptor-table register reads base 0 in bits [47:16] and limit 16'hFFFF in bits [15:0] of its slice of `dt_value`. Table k occupies bits [48k+47:48k].
- R11: `dt_ld[k]` loads `dt_wdata` into table k at the next edge. Other tables keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cop_type_strap | input | 1 | Coprocessor protocol type, captured during reset |
| cr_wr_en | input | 1 | Control-word write strobe |
| cr_wr_data | input | 32 | Control-word write value |
| task_sw | input | 1 | Task-switch strobe |
| fp_insn | input | 1 | Floating-point instruction decoded this cycle |
| wait_insn | input | 1 | Wait instruction decoded this cycle |
| cr_rd_data | output | 32 | Current control word |
| gp_fault | output | 1 | One-cycle pulse after a refused write |
| dna_fault | output | 1 | Device-not-available decision for this cycle |
| ext_proto32 | output | 1 | Effective 32-bit coprocessor protocol |
| dt_ld | input | NUM_DT | Per-table load strobes |
| dt_wdata | input | 48 | Value to load: base in [47:16], limit in [15:0] |
| dt_value | output | NUM_DT*48 | All table values, table k in slice k |

## Verification
A wrong emulate, monitor or task-switched bit does not stay hidden. It shows on `dna_fault` in the same cycle as the next floating-point or wait strobe, and it also reads back on `cr_rd_data` one edge after the write or task switch that caused it. A corrupted mode state appears at once as a forbidden paging-without-protection pattern on bits 31 and 0, or as a refused write that changed the word. Descriptor-table faults show on the `dt_value` slice one edge after the load strobe.

// File: rtl/mcr_pkg.sv
package mcr_pkg;
    localparam int CR_W       = 32;
    localparam int B_PROT     = 0;
    localparam int B_MONITOR  = 1;
    localparam int B_EMULATE  = 2;
    localparam int B_TSWITCH  = 3;
    localparam int B_EXTTYPE  = 4;
    localparam int B_NUMERR   = 5;
    localparam int B_WPROT    = 16;
    localparam int B_PAGING   = 31;

    typedef enum logic [1:0] {
        MODE_REAL  = 2'd0,
        MODE_PROT  = 2'd1,
        MODE_PAGED = 2'd2
    } mode_e;

    typedef struct packed {
        logic mon;
        logic emu;
        logic tsw;
        logic ext;
        logic nerr;
        logic wprot;
    } cop_bits_t;
endpackage

// File: rtl/mcr_mode_fsm.sv
module mcr_mode_fsm
    import mcr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic wr_en,
    input  logic wr_pe,
    input  logic wr_pg,
    output logic prot_on,
    output logic page_on,
    output logic gp_pulse
);
    mode_e state_q, state_d;
    logic  wr_legal;

    assign wr_legal = !(wr_pg && !wr_pe);

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= MODE_REAL;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        if (wr_en && wr_legal) begin
            unique case ({wr_pg, wr_pe})
                2'b00:   state_d = MODE_REAL;
                2'b01:   state_d = MODE_PROT;
                2'b11:   state_d = MODE_PAGED;
                default: state_d = state_q;
            endcase
        end
    end

    always_comb begin
        prot_on = 1'b0;
        page_on = 1'b0;
        unique case (state_q)
            MODE_REAL:  begin prot_on = 1'b0; page_on = 1'b0; end
            MODE_PROT:  begin prot_on = 1'b1; page_on = 1'b0; end
            MODE_PAGED: begin prot_on = 1'b1; page_on = 1'b1; end
            default:    begin prot_on = 1'b0; page_on = 1'b0; end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) gp_pulse <= 1'b0;
        else        gp_pulse <= wr_en && !wr_legal;
    end
endmodule

// File: rtl/mcr_cop_bits.sv
module mcr_cop_bits
    import mcr_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            type_strap,
    input  logic            wr_ok,
    input  logic [CR_W-1:0] wr_data,
    input  logic            task_sw,
    output cop_bits_t       bits
);
    cop_bits_t bits_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bits_q     <= '0;
            bits_q.ext <= type_strap;
        end else if (wr_ok) begin
            bits_q.mon   <= wr_data[B_MONITOR];
            bits_q.emu   <= wr_data[B_EMULATE];
            bits_q.tsw   <= wr_data[B_TSWITCH] | task_sw;
            bits_q.nerr  <= wr_data[B_NUMERR];
            bits_q.wprot <= wr_data[B_WPROT];
        end else if (task_sw) begin
            bits_q.tsw <= 1'b1;
        end
    end

    assign bits = bits_q;
endmodule

// File: rtl/mcr_trap_gate.sv
module mcr_trap_gate
    import mcr_pkg::*;
(
    input  cop_bits_t bits,
    input  logic      fp_insn,
    input  logic      wait_insn,
    output logic      dna,
    output logic      proto32
);
    logic fp_trap, wait_trap;

    always_comb begin
        fp_trap   = fp_insn && (bits.emu || bits.tsw);
        wait_trap = wait_insn && bits.mon && bits.tsw;
        dna       = fp_trap || wait_trap;
        proto32   = bits.ext && !bits.emu;
    end
endmodule

// File: rtl/mcr_dtab.sv
module mcr_dtab #(
    parameter int BASE_W = 32,
    parameter int LIM_W  = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    ld,
    input  logic [BASE_W+LIM_W-1:0] wdata,
    output logic [BASE_W+LIM_W-1:0] value
);
    localparam logic [BASE_W+LIM_W-1:0] RST_VAL = {{BASE_W{1'b0}}, {LIM_W{1'b1}}};

    always_ff @(posedge clk) begin
        if (!rst_n)  value <= RST_VAL;
        else if (ld) value <= wdata;
    end
endmodule

// File: rtl/mcr_top.sv
module mcr_top
    import mcr_pkg::*;
#(
    parameter int NUM_DT = 2,
    parameter int BASE_W = 32,
    parameter int LIM_W  = 16
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              cop_type_strap,
    input  logic                              cr_wr_en,
    input  logic [31:0]                       cr_wr_data,
    input  logic                              task_sw,
    input  logic                              fp_insn,
    input  logic                              wait_insn,
    output logic [31:0]                       cr_rd_data,
    output logic                              gp_fault,
    output logic                              dna_fault,
    output logic                              ext_proto32,
    input  logic [NUM_DT-1:0]                 dt_ld,
    input  logic [BASE_W+LIM_W-1:0]           dt_wdata,
    output logic [NUM_DT*(BASE_W+LIM_W)-1:0]  dt_value
);
    localparam int DT_W = BASE_W + LIM_W;

    logic      pe, pg, wr_ok;
    cop_bits_t cb;

    assign wr_ok = cr_wr_en && !(cr_wr_data[B_PAGING] && !cr_wr_data[B_PROT]);

    mcr_mode_fsm u_mode (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (cr_wr_en),
        .wr_pe    (cr_wr_data[B_PROT]),
        .wr_pg    (cr_wr_data[B_PAGING]),
        .prot_on  (pe),
        .page_on  (pg),
        .gp_pulse (gp_fault)
    );

    mcr_cop_bits u_bits (
        .clk        (clk),
        .rst_n      (rst_n),
        .type_strap (cop_type_strap),
        .wr_ok      (wr_ok),
        .wr_data    (cr_wr_data),
        .task_sw    (task_sw),
        .bits       (cb)
    );

    mcr_trap_gate u_gate (
        .bits      (cb),
        .fp_insn   (fp_insn),
        .wait_insn (wait_insn),
        .dna       (dna_fault),
        .proto32   (ext_proto32)
    );

    always_comb begin
        cr_rd_data            = '0;
        cr_rd_data[B_PROT]    = pe;
        cr_rd_data[B_MONITOR] = cb.mon;
        cr_rd_data[B_EMULATE] = cb.emu;
        cr_rd_data[B_TSWITCH] = cb.tsw;
        cr_rd_data[B_EXTTYPE] = cb.ext;
        cr_rd_data[B_NUMERR]  = cb.nerr;
        cr_rd_data[B_WPROT]   = cb.wprot;
        cr_rd_data[B_PAGING]  = pg;
    end

    for (genvar k = 0; k < NUM_DT; k++) begin : g_dt
        mcr_dtab #(.BASE_W(BASE_W), .LIM_W(LIM_W)) u_dt (
            .clk   (clk),
            .rst_n (rst_n),
            .ld    (dt_ld[k]),
            .wdata (dt_wdata),
            .value (dt_value[k*DT_W +: DT_W])
        );
    end
endmodule

// File: rtl/mcr_checker.sv
module mcr_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        cr_wr_en,
    input logic [31:0] cr_wr_data,
    input logic        task_sw,
    input logic        fp_insn,
    input logic        wait_insn,
    input logic [31:0] cr_rd_data,
    input logic        gp_fault,
    input logic        dna_fault,
    input logic        ext_proto32
);
    localparam logic [31:0] LIVE_MASK = 32'h8001_003F;

    assert_reserved_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cr_rd_data & ~LIVE_MASK) == 32'h0);

    assert_pg_needs_pe_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cr_rd_data[31] |-> cr_rd_data[0]);

    assert_refused_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cr_wr_en && cr_wr_data[31] && !cr_wr_data[0] && !task_sw)
        |=> (gp_fault && $stable(cr_rd_data)));

    assert_gp_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
        gp_fault |-> $past(cr_wr_en && cr_wr_data[31] && !cr_wr_data[0]));

    assert_ts_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
        task_sw |=> cr_rd_data[3]);

    assert_fp_emulate_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (fp_insn && cr_rd_data[2]) |-> dna_fault);

    assert_fp_switched_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (fp_insn && !cr_rd_data[2]) |-> (dna_fault == cr_rd_data[3]));

    assert_wait_rule_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wait_insn && !fp_insn) |-> (dna_fault == (cr_rd_data[1] && cr_rd_data[3])));

    assert_proto_masked_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cr_rd_data[2] |-> !ext_proto32);
endmodule

bind mcr_top mcr_checker u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cr_wr_en    (cr_wr_en),
    .cr_wr_data  (cr_wr_data),
    .task_sw     (task_sw),
    .fp_insn     (fp_insn),
    .wait_insn   (wait_insn),
    .cr_rd_data  (cr_rd_data),
    .gp_fault    (gp_fault),
    .dna_fault   (dna_fault),
    .ext_proto32 (ext_proto32)
);

// File: tb/mcr_top_tb.sv
module mcr_top_tb;
    localparam int NUM_DT = 2;
    localparam int DT_W   = 48;
    localparam logic [47:0] DT_RST = 48'h0000_0000_FFFF;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cop_type_strap = 1'b1;
    logic cr_wr_en = 1'b0;
    logic [31:0] cr_wr_data = '0;
    logic task_sw = 1'b0;
    logic fp_insn = 1'b0;
    logic wait_insn = 1'b0;
    logic [31:0] cr_rd_data;
    logic gp_fault, dna_fault, ext_proto32;
    logic [NUM_DT-1:0] dt_ld = '0;
    logic [DT_W-1:0] dt_wdata = '0;
    logic [NUM_DT*DT_W-1:0] dt_value;

    always #4 clk = ~clk;

    mcr_top u_dut (
        .clk(clk), .rst_n(rst_n), .cop_type_strap(cop_type_strap),
        .cr_wr_en(cr_wr_en), .cr_wr_data(cr_wr_data), .task_sw(task_sw),
        .fp_insn(fp_insn), .wait_insn(wait_insn), .cr_rd_data(cr_rd_data),
        .gp_fault(gp_fault), .dna_fault(dna_fault), .ext_proto32(ext_proto32),
        .dt_ld(dt_ld), .dt_wdata(dt_wdata), .dt_value(dt_value)
    );

    typedef enum int { S_CR, S_GP, S_DNA, S_EXT, S_DT0, S_DT1 } obs_e;
    typedef struct { obs_e sel; logic [47:0] exp; string req; } item_t;

    item_t sb_q[$];
    event  sample_ev;
    int    n_run = 0, n_fail = 0;
    bit    done = 0;

    function automatic logic [47:0] observe(obs_e s);
        case (s)
            S_CR:    return {16'h0, cr_rd_data};
            S_GP:    return {47'h0, gp_fault};
            S_DNA:   return {47'h0, dna_fault};
            S_EXT:   return {47'h0, ext_proto32};
            S_DT0:   return dt_value[0 +: DT_W];
            default: return dt_value[DT_W +: DT_W];
        endcase
    endfunction

    initial begin
        forever begin
            @(sample_ev);
            while (sb_q.size() > 0) begin
                item_t it;
                logic [47:0] act;
                it  = sb_q.pop_front();
                act = observe(it.sel);
                n_run++;
                if (act !== it.exp) begin
                    n_fail++;
                    $display("FAIL %s %s: actual %h expected %h", it.req, it.sel.name(), act, it.exp);
                end
            end
        end
    end

    task automatic expect_v(obs_e s, logic [47:0] e, string r);
        item_t it;
        it.sel = s; it.exp = e; it.req = r;
        sb_q.push_back(it);
    endtask

    task automatic settle();
        -> sample_ev;
        #1;
    endtask

    task automatic cr_write(logic [31:0] v, logic sw);
        @(negedge clk);
        cr_wr_en = 1'b1; cr_wr_data = v; task_sw = sw;
        @(negedge clk);
        cr_wr_en = 1'b0; task_sw = 1'b0;
        #1;
    endtask

    task automatic probe(logic fp, logic wt, logic e, string r);
        @(negedge clk);
        fp_insn = fp; wait_insn = wt;
        #1;
        expect_v(S_DNA, {47'h0, e}, r);
        settle();
        fp_insn = 1'b0; wait_insn = 1'b0;
    endtask

    task automatic do_reset(logic strap);
        @(negedge clk);
        rst_n = 1'b0; cop_type_strap = strap;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
    endtask

    initial begin
        do_reset(1'b1);
        expect_v(S_CR, 48'h10, "R1");
        expect_v(S_GP, 48'h0, "R1");
        expect_v(S_EXT, 48'h1, "R9");
        expect_v(S_DT0, DT_RST, "R10");
        expect_v(S_DT1, DT_RST, "R10");
        settle();

        // R3: paging without protection is refused
        cr_write(32'h8000_0000, 1'b0);
        expect_v(S_CR, 48'h10, "R3");
        expect_v(S_GP, 48'h1, "R3");
        settle();
        @(negedge clk); #1;
        expect_v(S_GP, 48'h0, "R3");
        settle();

        // R2 R4: all writable bits, bit 4 preserved
        cr_write(32'hFFFF_FFFF, 1'b0);
        expect_v(S_CR, 48'h8001_003F, "R2");
        expect_v(S_GP, 48'h0, "R4");
        expect_v(S_EXT, 48'h0, "R9");
        settle();
        cr_write(32'h0, 1'b0);
        expect_v(S_CR, 48'h10, "R2");
        expect_v(S_EXT, 48'h1, "R9");
        settle();
        cr_write(32'h1, 1'b0);
        expect_v(S_CR, 48'h11, "R4");
        settle();
        cr_write(32'h8000_0001, 1'b0);
        expect_v(S_CR, 48'h8000_0011, "R4");
        settle();

        // R6: emulate traps floating point, not wait
        cr_write(32'h4, 1'b0);
        expect_v(S_CR, 48'h14, "R6");
        settle();
        probe(1'b1, 1'b0, 1'b1, "R6");
        probe(1'b0, 1'b1, 1'b0, "R8");

        // R7: no trap with both clear
        cr_write(32'h0, 1'b0);
        probe(1'b1, 1'b0, 1'b0, "R7");
        probe(1'b0, 1'b1, 1'b0, "R8");

        // R5: task switch alone sets bit 3
        @(negedge clk); task_sw = 1'b1;
        @(negedge clk); task_sw = 1'b0; #1;
        expect_v(S_CR, 48'h18, "R5");
        settle();
        probe(1'b1, 1'b0, 1'b1, "R7");
        probe(1'b0, 1'b1, 1'b0, "R8");

        // R8: monitor with task-switched traps wait
        cr_write(32'hA, 1'b0);
        expect_v(S_CR, 48'h1A, "R8");
        settle();
        probe(1'b0, 1'b1, 1'b1, "R8");
        cr_write(32'h2, 1'b0);
        probe(1'b0, 1'b1, 1'b0, "R8");

        // R5: write and task switch together
        cr_write(32'h2, 1'b1);
        expect_v(S_CR, 48'h1A, "R5");
        settle();
        cr_write(32'h2, 1'b0);
        cr_write(32'h8000_0000, 1'b1);
        expect_v(S_CR, 48'h1A, "R5");
        expect_v(S_GP, 48'h1, "R3");
        settle();

        // R8: emulate does not affect wait
        cr_write(32'hC, 1'b0);
        probe(1'b1, 1'b0, 1'b1, "R6");
        probe(1'b0, 1'b1, 1'b0, "R8");

        // R11: per-table load
        @(negedge clk);
        dt_ld = 2'b01; dt_wdata = 48'h1234_5678_00FF;
        @(negedge clk);
        dt_ld = 2'b00; #1;
        expect_v(S_DT0, 48'h1234_5678_00FF, "R11");
        expect_v(S_DT1, DT_RST, "R11");
        settle();
        @(negedge clk);
        dt_ld = 2'b10; dt_wdata = 48'hCAFE_0000_0123;
        @(negedge clk);
        dt_ld = 2'b00; #1;
        expect_v(S_DT0, 48'h1234_5678_00FF, "R11");
        expect_v(S_DT1, 48'hCAFE_0000_0123, "R11");
        settle();

        // R1 R9 R10: reset with strap low
        do_reset(1'b0);
        expect_v(S_CR, 48'h0, "R1");
        expect_v(S_EXT, 48'h0, "R9");
        expect_v(S_DT0, DT_RST, "R10");
        settle();

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule